// File: doc/BRIEF.md
# Hamming Sector ECC Checker-Corrector

This block protects one flash sector of `SECTOR_BYTES` bytes (512 by default) with a Hamming-style parity code. Bytes arrive on a valid/ready stream. A start-of-sector flag on the first byte discards any earlier accumulation. After the last byte, `code_out` holds the code to write to the spare area. With the default size the code is 24 bits, written as three bytes, low byte first.

The parity is kept in two halves of `H = AW + 3` bits each, where `AW` is the byte-index width:
- The upper half holds even parities in the "one" form. Bit k covers every data bit whose address has bit k set. The address of a data bit is its byte index times eight plus its bit position.
- The lower half holds the same parities in the "zero" form.
- The stored code is the bit-inverse of `{one, zero}`. An erased sector, with every byte 0xFF, therefore yields an all-ones code and checks clean.

On read-back the sector is streamed in again. A strobe on `chk_go` then compares the stored code on `chk_code` with the code just accumulated, and the result is classified. A single flipped data bit is reported by byte and bit. The block then repairs it in an external sector buffer through a read, then write, port. The buffer's read port has one cycle of latency. A single flipped bit inside the stored code is reported as corrected, and the data is left alone.

Back-pressure rules:
- `s_ready` is high except during the two buffer-repair cycles.
- A byte is taken on a clock edge where both `s_valid` and `s_ready` are high.
- While `s_ready` is low, the producer must hold its byte.

Top module: `hamming_sector_ecc`

## Requirements
- R1: After reset, `code_out` is all ones, `st_valid`, `buf_rd_en` and `buf_wr_en` are low, and `s_ready` is high.
- R2: One cycle after each accepted byte, `code_out` equals the inverse of `{one, zero}` over the bytes accepted since the last start flag. The parities are as defined above, with bit positions 0-2 of the address being the bit within the byte. `code_out[7:0]` is the first stored byte.
- R3: A full sector of 0xFF bytes yields `code_out` all ones (0xFFFFFF for 512 bytes).
- R4: An accepted byte with `s_first` high discards the earlier accumulation and counts as byte index 0.
- R5: On `chk_go`, a zero mismatch (`chk_code ^ code_out`) gives status none (`st_kind` = 0), `st_data_fix` low, and no buffer access.
- R6: Split the mismatch into halves `hi = m[2H-1:H]` and `lo = m[H-1:0]`. If `hi ^ lo` is all ones and the byte index `hi[H-1:3]` is below `SECTOR_BYTES`, the result is:
  - `st_kind` = 1 (corrected) and `st_data_fix` high;
  - `fix_byte` = `hi[H-1:3]` (`m[23:15]` for 512 bytes);
  - `fix_bit` = `hi[2:0]` (`m[14:12]`).
- R7: A data fix reads the buffer at `fix_byte` in the cycle after the status appears. In the next cycle it writes the same address with the read byte, with bit `fix_bit` inverted.
- R8: A mismatch with exactly one bit set gives `st_kind` = 1 with `st_data_fix` low, `fix_byte` and `fix_bit` zero, and no buffer access.
- R9: Any other nonzero mismatch gives `st_kind` = 2 (uncorrectable) and no buffer access.
- R10: A mismatch that passes the complement test but names a byte index at or above `SECTOR_BYTES` gives `st_kind` = 2 and no buffer access.
- R11: `s_ready` is low during the buffer read and write cycles. A `chk_go` in those cycles is ignored.
- R12: `st_valid` pulses for exactly the cycle after an accepted `chk_go`. The status fields hold until the next accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream ready, low while a repair runs |
| s_first | input | 1 | Byte is the first of a sector |
| s_data | input | 8 | Stream byte |
| code_out | output | CW | Inverted code of the bytes so far, low byte first |
| chk_go | input | 1 | Compare strobe |
| chk_code | input | CW | Stored code to compare against |
| st_valid | output | 1 | Status pulse |
| st_kind | output | 2 | 0 none, 1 corrected, 2 uncorrectable |
| st_data_fix | output | 1 | Correction applies to a data bit |
| fix_byte | output | AW | Byte index of the bad bit |
| fix_bit | output | 3 | Bit position of the bad bit |
| buf_rd_en | output | 1 | Buffer read strobe |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_addr | output | AW | Buffer byte address |
| buf_wr_data | output | 8 | Repaired byte |
| buf_rd_data | input | 8 | Buffer read data, one cycle after the read strobe |

## Verification
The bench builds two instances.

The first uses the default 512-byte sector with a 24-bit code. Random sectors with random stream gaps exercise:
- single-bit repairs, including the first and the last bit of the sector;
- erased sectors;
- restarts in the middle of a stream;
- errors that fall only in the code, and double errors.

The second uses a 24-byte sector. There, the 5-bit byte-index field can name indices 24 to 31, past the end of the sector. This brings the out-of-range rule within reach; it cannot occur at 512, where every 9-bit index is valid.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  typedef enum logic [1:0] {
    ST_NONE      = 2'd0,
    ST_CORRECTED = 2'd1,
    ST_UNCORR    = 2'd2
  } ecc_status_e;

  // Select bit lanes of a byte whose lane number has bit k equal to sel.
  function automatic logic [7:0] lane_mask(input int unsigned k, input logic sel);
    logic [7:0] m;
    for (int j = 0; j < 8; j++) begin
      m[j] = ((((j >> k) & 1) != 0) == sel);
    end
    return m;
  endfunction
endpackage

// File: rtl/ecc_parity_acc.sv
module ecc_parity_acc #(
  parameter int unsigned AW = 9,
  localparam int unsigned H = AW + 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic           first,
  input  logic [7:0]     data,
  output logic [2*H-1:0] code_inv
);
  logic [H-1:0]  one_q, zero_q;
  logic [AW-1:0] idx_q;
  logic [AW-1:0] cur_idx;
  logic [H-1:0]  base_one, base_zero;
  logic [H-1:0]  c_one, c_zero;
  logic          par;

  assign cur_idx   = first ? '0 : idx_q;
  assign base_one  = first ? '0 : one_q;
  assign base_zero = first ? '0 : zero_q;
  assign par       = ^data;

  // Bit-within-byte address lanes.
  for (genvar k = 0; k < 3; k++) begin : g_bitlane
    localparam logic [7:0] MSEL = ecc_pkg::lane_mask(k, 1'b1);
    assign c_one[k]  = ^(data & MSEL);
    assign c_zero[k] = ^(data & ~MSEL);
  end

  // Byte-index address lanes: whole-byte parity gated by the index bit.
  for (genvar k = 0; k < AW; k++) begin : g_bytelane
    assign c_one[3+k]  = cur_idx[k] & par;
    assign c_zero[3+k] = ~cur_idx[k] & par;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      one_q  <= '0;
      zero_q <= '0;
      idx_q  <= '0;
    end else if (take) begin
      one_q  <= base_one ^ c_one;
      zero_q <= base_zero ^ c_zero;
      idx_q  <= cur_idx + AW'(1);
    end
  end

  assign code_inv = ~{one_q, zero_q};

  p_restart_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && first) |=> (idx_q == AW'(1)));

  p_code_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(code_inv));
endmodule

// File: rtl/ecc_syndrome.sv
module ecc_syndrome #(
  parameter int unsigned SECTOR_BYTES = 512,
  parameter int unsigned AW = 9,
  localparam int unsigned H = AW + 3
) (
  input  logic [2*H-1:0]         stored,
  input  logic [2*H-1:0]         calc,
  output ecc_pkg::ecc_status_e   kind,
  output logic                   data_fix,
  output logic [AW-1:0]          byte_idx,
  output logic [2:0]             bit_idx
);
  import ecc_pkg::*;

  localparam logic [AW:0] LIMIT = (AW+1)'(SECTOR_BYTES);

  logic [2*H-1:0] m;
  logic [H-1:0]   hi, lo;
  logic           compl_ok, in_range;

  assign m        = stored ^ calc;
  assign hi       = m[2*H-1:H];
  assign lo       = m[H-1:0];
  assign compl_ok = &(hi ^ lo);
  assign in_range = ({1'b0, hi[H-1:3]} < LIMIT);

  always_comb begin
    kind     = ST_UNCORR;
    data_fix = 1'b0;
    byte_idx = '0;
    bit_idx  = '0;
    if (m == '0) begin
      kind = ST_NONE;
    end else if (compl_ok) begin
      if (in_range) begin
        kind     = ST_CORRECTED;
        data_fix = 1'b1;
        byte_idx = hi[H-1:3];
        bit_idx  = hi[2:0];
      end
    end else if ($onehot(m)) begin
      kind = ST_CORRECTED;
    end
  end
endmodule

// File: rtl/ecc_fix_seq.sv
module ecc_fix_seq #(
  parameter int unsigned AW = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  ecc_pkg::ecc_status_e kind_in,
  input  logic                 fix_in,
  input  logic [AW-1:0]        byte_in,
  input  logic [2:0]           bit_in,
  input  logic [7:0]           buf_rd_data,
  output logic                 idle,
  output logic                 st_valid,
  output ecc_pkg::ecc_status_e st_kind,
  output logic                 st_data_fix,
  output logic [AW-1:0]        fix_byte,
  output logic [2:0]           fix_bit,
  output logic                 buf_rd_en,
  output logic                 buf_wr_en,
  output logic [AW-1:0]        buf_addr,
  output logic [7:0]           buf_wr_data
);
  import ecc_pkg::*;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} fix_state_e;
  fix_state_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      st_valid    <= 1'b0;
      st_kind     <= ST_NONE;
      st_data_fix <= 1'b0;
      fix_byte    <= '0;
      fix_bit     <= '0;
    end else begin
      st_valid <= 1'b0;
      unique case (state_q)
        S_IDLE: if (go) begin
          st_valid    <= 1'b1;
          st_kind     <= kind_in;
          st_data_fix <= fix_in;
          fix_byte    <= fix_in ? byte_in : '0;
          fix_bit     <= fix_in ? bit_in : '0;
          if (fix_in) state_q <= S_RD;
        end
        S_RD:    state_q <= S_WR;
        S_WR:    state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign idle        = (state_q == S_IDLE);
  assign buf_rd_en   = (state_q == S_RD);
  assign buf_wr_en   = (state_q == S_WR);
  assign buf_addr    = fix_byte;
  assign buf_wr_data = buf_rd_data ^ 8'(8'h01 << fix_bit);

  p_write_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_en |=> (buf_wr_en && $stable(buf_addr)));

  p_status_after_go_r12: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> $past(go && idle));

  p_fix_only_corrected_r9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_en |-> (st_kind == ST_CORRECTED && st_data_fix));
endmodule

// File: rtl/hamming_sector_ecc.sv
module hamming_sector_ecc #(
  parameter int unsigned SECTOR_BYTES = 512,
  localparam int unsigned AW = $clog2(SECTOR_BYTES),
  localparam int unsigned H  = AW + 3,
  localparam int unsigned CW = 2 * H
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic          s_first,
  input  logic [7:0]    s_data,
  output logic [CW-1:0] code_out,
  input  logic          chk_go,
  input  logic [CW-1:0] chk_code,
  output logic          st_valid,
  output logic [1:0]    st_kind,
  output logic          st_data_fix,
  output logic [AW-1:0] fix_byte,
  output logic [2:0]    fix_bit,
  output logic          buf_rd_en,
  output logic          buf_wr_en,
  output logic [AW-1:0] buf_addr,
  output logic [7:0]    buf_wr_data,
  input  logic [7:0]    buf_rd_data
);
  import ecc_pkg::*;

  localparam logic [AW:0] LIMIT = (AW+1)'(SECTOR_BYTES);

  logic          idle, take;
  ecc_status_e   syn_kind, st_kind_e;
  logic          syn_fix;
  logic [AW-1:0] syn_byte;
  logic [2:0]    syn_bit;

  assign s_ready = idle;
  assign take    = s_valid && idle;
  assign st_kind = st_kind_e;

  ecc_parity_acc #(.AW(AW)) u_acc (
    .clk(clk), .rst_n(rst_n), .take(take), .first(s_first),
    .data(s_data), .code_inv(code_out)
  );

  ecc_syndrome #(.SECTOR_BYTES(SECTOR_BYTES), .AW(AW)) u_syn (
    .stored(chk_code), .calc(code_out), .kind(syn_kind),
    .data_fix(syn_fix), .byte_idx(syn_byte), .bit_idx(syn_bit)
  );

  ecc_fix_seq #(.AW(AW)) u_fix (
    .clk(clk), .rst_n(rst_n), .go(chk_go), .kind_in(syn_kind),
    .fix_in(syn_fix), .byte_in(syn_byte), .bit_in(syn_bit),
    .buf_rd_data(buf_rd_data), .idle(idle), .st_valid(st_valid),
    .st_kind(st_kind_e), .st_data_fix(st_data_fix), .fix_byte(fix_byte),
    .fix_bit(fix_bit), .buf_rd_en(buf_rd_en), .buf_wr_en(buf_wr_en),
    .buf_addr(buf_addr), .buf_wr_data(buf_wr_data)
  );

  p_busy_blocks_stream_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd_en || buf_wr_en) |-> !s_ready);

  p_fix_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    st_data_fix |-> ({1'b0, fix_byte} < LIMIT));
endmodule

// File: tb/sim_hamming_sector_ecc.sv
module sim_hamming_sector_ecc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  // Instance u0: 512-byte sector
  logic        s_valid, s_ready, s_first, chk_go;
  logic [7:0]  s_data, buf_wr_data, buf_rd_data;
  logic [23:0] code0, chk_code;
  logic        st_valid, st_data_fix, buf_rd_en, buf_wr_en;
  logic [1:0]  st_kind;
  logic [8:0]  fix_byte, buf_addr;
  logic [2:0]  fix_bit;

  hamming_sector_ecc u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_first(s_first), .s_data(s_data), .code_out(code0), .chk_go(chk_go),
    .chk_code(chk_code), .st_valid(st_valid), .st_kind(st_kind),
    .st_data_fix(st_data_fix), .fix_byte(fix_byte), .fix_bit(fix_bit),
    .buf_rd_en(buf_rd_en), .buf_wr_en(buf_wr_en), .buf_addr(buf_addr),
    .buf_wr_data(buf_wr_data), .buf_rd_data(buf_rd_data)
  );

  // Instance u1: 24-byte sector, read data tied low
  logic        s_ready1, chk_go1, st_valid1, st_fix1, rd_en1, wr_en1;
  logic [15:0] code1, chk_code1;
  logic [1:0]  st_kind1;
  logic [4:0]  fix_byte1, addr1;
  logic [2:0]  fix_bit1;
  logic [7:0]  wr_data1;

  hamming_sector_ecc #(.SECTOR_BYTES(24)) u1 (
    .clk(clk), .rst_n(rst_n), .s_valid(1'b0), .s_ready(s_ready1),
    .s_first(1'b0), .s_data(8'h00), .code_out(code1), .chk_go(chk_go1),
    .chk_code(chk_code1), .st_valid(st_valid1), .st_kind(st_kind1),
    .st_data_fix(st_fix1), .fix_byte(fix_byte1), .fix_bit(fix_bit1),
    .buf_rd_en(rd_en1), .buf_wr_en(wr_en1), .buf_addr(addr1),
    .buf_wr_data(wr_data1), .buf_rd_data(8'h00)
  );

  // Sector buffer model: bench load port plus the block's read/write port
  logic [7:0] bmem [0:511];
  logic       ld_en;
  logic [8:0] ld_addr;
  logic [7:0] ld_data;
  always @(posedge clk) begin
    if (ld_en) bmem[ld_addr] <= ld_data;
    if (buf_rd_en) buf_rd_data <= bmem[buf_addr];
    if (buf_wr_en) bmem[buf_addr] <= buf_wr_data;
  end

  logic [7:0] ref_sec [0:511];
  logic [7:0] cur_sec [0:511];
  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Code model from the requirement text: one/zero parities over bit addresses
  function automatic logic [23:0] model_code(input bit use_ref);
    logic [11:0] one_p = '0;
    logic [11:0] zero_p = '0;
    logic [7:0]  b;
    logic [11:0] a;
    for (int i = 0; i < 512; i++) begin
      b = use_ref ? ref_sec[i] : cur_sec[i];
      for (int j = 0; j < 8; j++) begin
        if (b[j]) begin
          a = {9'(i), 3'(j)};
          for (int k = 0; k < 12; k++) begin
            if (a[k]) one_p[k] = ~one_p[k];
            else      zero_p[k] = ~zero_p[k];
          end
        end
      end
    end
    return ~{one_p, zero_p};
  endfunction

  function automatic int diff_vs_ref();
    int d = 0;
    for (int i = 0; i < 512; i++) if (bmem[i] !== ref_sec[i]) d++;
    return d;
  endfunction

  task automatic fill_random();
    for (int i = 0; i < 512; i++) begin
      ref_sec[i] = 8'($urandom);
      cur_sec[i] = ref_sec[i];
    end
  endtask

  // Stream the first n bytes of cur_sec with random gaps, loading the buffer too
  task automatic stream(input int n);
    int i = 0;
    while (i < n) begin
      @(negedge clk);
      if ($urandom_range(0, 5) == 0) begin
        s_valid = 1'b0;
        ld_en   = 1'b0;
      end else begin
        s_valid = 1'b1;
        s_first = (i == 0);
        s_data  = cur_sec[i];
        ld_en   = 1'b1;
        ld_addr = 9'(i);
        ld_data = cur_sec[i];
        if (s_ready) i++;
      end
    end
    @(negedge clk);
    s_valid = 1'b0;
    s_first = 1'b0;
    ld_en   = 1'b0;
  endtask

  task automatic run_cmp(input logic [23:0] stored, input logic [1:0] ek,
                         input logic ef, input logic [8:0] eb,
                         input logic [2:0] et, input bit hold2,
                         input string tag);
    @(negedge clk);
    chk_go   = 1'b1;
    chk_code = stored;
    @(negedge clk);
    chk_go = hold2;
    check("R12", "st_valid pulse", 32'(st_valid), 32'd1);
    check(tag, "st_kind", 32'(st_kind), 32'(ek));
    check(tag, "st_data_fix", 32'(st_data_fix), 32'(ef));
    check(tag, "fix_byte", 32'(fix_byte), 32'(eb));
    check(tag, "fix_bit", 32'(fix_bit), 32'(et));
    check(tag, "buf_rd_en", 32'(buf_rd_en), 32'(ef));
    if (ef) begin
      check("R11", "s_ready during read", 32'(s_ready), 32'd0);
      check("R7", "buf_addr", 32'(buf_addr), 32'(eb));
    end
    @(negedge clk);
    chk_go = 1'b0;
    check("R12", "st_valid one cycle", 32'(st_valid), 32'd0);
    check(tag, "buf_wr_en", 32'(buf_wr_en), 32'(ef));
    if (ef) check("R11", "s_ready during write", 32'(s_ready), 32'd0);
    @(negedge clk);
    check("R11", "s_ready back", 32'(s_ready), 32'd1);
    check("R12", "st_kind held", 32'(st_kind), 32'(ek));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int b, t, b2;
    logic [23:0] stored;
    void'($urandom(32'h1d2c));
    s_valid = 0; s_first = 0; s_data = 0; chk_go = 0; chk_code = 0;
    chk_go1 = 0; chk_code1 = 0; ld_en = 0; ld_addr = 0; ld_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R1", "code_out", 32'(code0), 32'hFFFFFF);
    check("R1", "st_valid", 32'(st_valid), 32'd0);
    check("R1", "s_ready", 32'(s_ready), 32'd1);
    check("R1", "buffer strobes", 32'({buf_rd_en, buf_wr_en}), 32'd0);

    // Erased sector
    for (int i = 0; i < 512; i++) begin
      ref_sec[i] = 8'hFF;
      cur_sec[i] = 8'hFF;
    end
    stream(512);
    check("R3", "erased code", 32'(code0), 32'hFFFFFF);
    run_cmp(24'hFFFFFF, 2'd0, 1'b0, 9'd0, 3'd0, 1'b0, "R5");
    check("R5", "buffer untouched", 32'(diff_vs_ref()), 32'd0);

    // Single data-bit errors, including both ends of the sector
    for (int r = 0; r < 4; r++) begin
      fill_random();
      b = $urandom_range(0, 511);
      t = $urandom_range(0, 7);
      if (r == 0) begin b = 0; t = 0; end
      if (r == 1) begin b = 511; t = 7; end
      cur_sec[b] = cur_sec[b] ^ 8'(1 << t);
      stream(512);
      check("R2", "code of streamed sector", 32'(code0), 32'(model_code(1'b0)));
      run_cmp(model_code(1'b1), 2'd1, 1'b1, 9'(b), 3'(t), (r == 0), "R6");
      check("R7", "buffer repaired", 32'(diff_vs_ref()), 32'd0);
    end

    // Restart in the middle of a stream
    fill_random();
    stream(100);
    fill_random();
    stream(512);
    check("R4", "code after restart", 32'(code0), 32'(model_code(1'b1)));

    // Error confined to the stored code
    stored = model_code(1'b1) ^ 24'h000008;
    run_cmp(stored, 2'd1, 1'b0, 9'd0, 3'd0, 1'b0, "R8");
    stored = model_code(1'b1) ^ 24'h100000;
    run_cmp(stored, 2'd1, 1'b0, 9'd0, 3'd0, 1'b0, "R8");
    check("R8", "data unchanged", 32'(diff_vs_ref()), 32'd0);

    // Double data-bit error
    fill_random();
    b  = $urandom_range(0, 255);
    b2 = $urandom_range(256, 511);
    cur_sec[b]  = cur_sec[b] ^ 8'h04;
    cur_sec[b2] = cur_sec[b2] ^ 8'h40;
    stream(512);
    run_cmp(model_code(1'b1), 2'd2, 1'b0, 9'd0, 3'd0, 1'b0, "R9");
    check("R9", "buffer left as read", 32'(diff_vs_ref()), 32'd2);

    // Small instance: byte index past the sector end
    @(negedge clk);
    chk_go1 = 1'b1;
    chk_code1 = 16'h1EE1;
    @(negedge clk);
    chk_go1 = 1'b0;
    check("R10", "st_valid", 32'(st_valid1), 32'd1);
    check("R10", "st_kind out of range", 32'(st_kind1), 32'd2);
    check("R10", "no read", 32'(rd_en1), 32'd0);
    @(negedge clk);
    check("R10", "no write", 32'(wr_en1), 32'd0);

    // Small instance: in-range repair, byte 5 bit 2, buffer reads zero
    @(negedge clk);
    chk_go1 = 1'b1;
    chk_code1 = 16'hD52A;
    @(negedge clk);
    chk_go1 = 1'b0;
    check("R6", "small st_kind", 32'(st_kind1), 32'd1);
    check("R6", "small fix_byte", 32'(fix_byte1), 32'd5);
    check("R6", "small fix_bit", 32'(fix_bit1), 32'd2);
    check("R7", "small read", 32'(rd_en1), 32'd1);
    @(negedge clk);
    check("R7", "small write", 32'(wr_en1), 32'd1);
    check("R7", "small write data", 32'(wr_data1), 32'h04);
    check("R7", "small write addr", 32'(addr1), 32'd5);
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule